// File: doc/BRIEF.md
# Parallel NOR Flash Command Sequencer

The sequencer turns a single host request into the complete series of bus cycles that an asynchronous parallel NOR flash expects for one operation. The host pulses a start strobe together with a 3-bit operation code, a target word address, a data word and, for buffered programming, a word count. The block then drives chip enable, write enable, output enable, the address bus and a separately enabled data bus. It emits the two-write unlock prefix where the operation needs it, then the command code, then any trailing address, data or read cycles.

Each bus cycle holds its strobe low for a fixed number of clock cycles set by a parameter. Every cycle is followed by one quiet cycle in which all strobes are high and the data bus is released. Identifier and query reads return the captured word on a one-cycle valid pulse. Buffered programming takes its data words one at a time from the host data input, and a take pulse tells the host to present the next word. A build-time parameter selects a 16-bit device, which gets word addresses, or an 8-bit device, which gets byte addresses. Polling the flash for completion is left to another block.

Top module: `nor_cmd_seq`

## Requirements
- R1: After reset, busy, done, rd_valid, data_take and flash_doe are 0, and flash_ce_n, flash_we_n and flash_oe_n are 1.
- R2: An accepted start raises busy on the next clock edge. Busy stays high for exactly 1 + N*(WR_CYC+1) clock cycles for a sequence of N bus cycles. Done pulses high for one cycle as busy falls. A start that arrives while busy has no effect on the sequence in progress, and operation code 7 is never accepted.
- R3: A bus cycle holds flash_ce_n low for exactly WR_CYC clock cycles. A write also holds flash_we_n low with flash_oe_n high and flash_doe = 1. A read holds flash_oe_n low with flash_we_n high and flash_doe = 0. Between cycles, all strobes are high and flash_doe = 0.
- R4: Operation 0 (return to read mode) is one write of 0xF0 to address 0.
- R5: Operation 3 (single-word program) is four writes: 0xAA to 0x555, 0x55 to 0x2AA, 0xA0 to 0x555, then the request data word to the request address.
- R6: Operation 5 (sector erase) is six writes: 0xAA@0x555, 0x55@0x2AA, 0x80@0x555, 0xAA@0x555, 0x55@0x2AA, then 0x30 to the request address.
- R7: Operation 6 (chip erase) uses the same first five writes as sector erase, and its sixth write is 0x10 to 0x555.
- R8: Operation 1 (read identifiers) is the unlock pair, then 0x90@0x555, then four reads at word addresses 0x00, 0x01, 0x0E and 0x0F. Each read returns the sampled flash_din on rd_data with a one-cycle rd_valid pulse.
- R9: Operation 2 (query) is one write of 0x98 to 0x055 with no unlock prefix, then four reads at 0x10, 0x11, 0x12 and 0x13, each returned as in R8.
- R10: Operation 4 (buffered program) with count n is the unlock pair, 0x25 to the address A, n-1 to A, then n data writes to A, A+1, …, A+n-1, and finally 0x29 to A+n-1. Addresses wrap modulo 2^AW. Each data write carries the req_data value present when that cycle begins, and pulses data_take once.
- R11: Operation 4 with count 0 or count greater than MAXW is not accepted: busy stays low and no bus cycle occurs.
- R12: With BYTE_MODE = 1, flash_addr is the word address shifted left by one bit. All other outputs are identical to the word-mode build.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_start | input | 1 | Start strobe, sampled only while idle |
| req_op | input | 3 | Operation code 0..6 (7 is rejected) |
| req_addr | input | AW | Target word or sector address |
| req_data | input | DW | Program data; streamed word for buffered program |
| req_count | input | clog2(MAXW+1) | Word count for buffered program |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse at the end of a sequence |
| data_take | output | 1 | Pulse: the current req_data word was taken |
| rd_data | output | DW | Word captured by the last read cycle |
| rd_valid | output | 1 | Pulse: rd_data updated |
| flash_addr | output | AW+1 | Flash address bus |
| flash_dout | output | DW | Flash write data |
| flash_doe | output | 1 | Drive enable for flash_dout |
| flash_din | input | DW | Flash read data |
| flash_ce_n | output | 1 | Chip enable, active low |
| flash_we_n | output | 1 | Write enable, active low |
| flash_oe_n | output | 1 | Output enable, active low |

## Verification
The embedded properties check bus hygiene on every cycle: write and output enables are never low together, no strobe is low without chip enable, the data bus is driven during writes and released during reads, the block is quiet whenever it is idle, done pulses only as busy ends, the latched operation stays fixed while busy, and the strobe counter stays in range. The exact address and data order of each operation, the wrap of buffered addresses, the strobe width and the busy length cannot be seen this way. Neither can the read data returned, the rejection of bad counts or the byte-address build. Only the bench's recorded bus traces, compared with sequences it builds itself, show those.

// File: rtl/nor_seq_pkg.sv
package nor_seq_pkg;

  typedef enum logic [2:0] {
    OP_READ_RESET = 3'd0,
    OP_READ_ID    = 3'd1,
    OP_QUERY      = 3'd2,
    OP_PROG       = 3'd3,
    OP_BUF_PROG   = 3'd4,
    OP_SECT_ERASE = 3'd5,
    OP_CHIP_ERASE = 3'd6,
    OP_NONE       = 3'd7
  } nor_op_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_GAP,
    ST_STROBE
  } seq_st_e;

  // command word addresses
  localparam logic [11:0] A_KEY_HI    = 12'h555;
  localparam logic [11:0] A_KEY_LO    = 12'h2AA;
  localparam logic [11:0] A_QRY_CMD   = 12'h055;
  localparam logic [11:0] A_QRY_DATA  = 12'h010;

  // command codes
  localparam logic [7:0] K_KEY1       = 8'hAA;
  localparam logic [7:0] K_KEY2       = 8'h55;
  localparam logic [7:0] K_IDENT      = 8'h90;
  localparam logic [7:0] K_WORD_PROG  = 8'hA0;
  localparam logic [7:0] K_ERASE_ARM  = 8'h80;
  localparam logic [7:0] K_SECTOR     = 8'h30;
  localparam logic [7:0] K_WHOLE      = 8'h10;
  localparam logic [7:0] K_QUERY      = 8'h98;
  localparam logic [7:0] K_BUF_LOAD   = 8'h25;
  localparam logic [7:0] K_BUF_COMMIT = 8'h29;
  localparam logic [7:0] K_ARRAY_MODE = 8'hF0;

endpackage

// File: rtl/nor_strobe_timer.sv
module nor_strobe_timer #(
  parameter int WR_CYC = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic fin
);
  localparam int TW = (WR_CYC > 1) ? $clog2(WR_CYC) : 1;

  logic [TW-1:0] tcnt;

  assign fin = run && (int'(tcnt) == WR_CYC - 1);

  always_ff @(posedge clk) begin
    if (rst || !run || fin) tcnt <= '0;
    else                    tcnt <= tcnt + 1'b1;
  end

  // R3: the strobe counter never passes the programmed width
  p_tcnt_bound_r3: assert property (@(posedge clk) disable iff (rst)
    int'(tcnt) < WR_CYC);

  // R3: a strobe ends once, then the state machine leaves the strobe
  p_fin_single_r3: assert property (@(posedge clk) disable iff (rst)
    fin |=> !fin);

endmodule

// File: rtl/nor_seq_plan.sv
module nor_seq_plan import nor_seq_pkg::*; #(
  parameter int AW   = 20,
  parameter int DW   = 16,
  parameter int MAXW = 16,
  parameter int SW   = 5,
  parameter int CW   = 5
) (
  input  nor_op_e         op,
  input  logic [SW-1:0]   step,
  input  logic [AW-1:0]   base,
  input  logic [DW-1:0]   prog_word,
  input  logic [DW-1:0]   stream_word,
  input  logic [CW-1:0]   count,
  output logic            is_read,
  output logic [AW-1:0]   cyc_addr,
  output logic [DW-1:0]   cyc_data,
  output logic            is_last,
  output logic            takes_word
);

  always_comb begin
    int s;
    int n;
    s          = int'(step);
    n          = int'(count);
    is_read    = 1'b0;
    cyc_addr   = '0;
    cyc_data   = '0;
    is_last    = 1'b0;
    takes_word = 1'b0;
    if (op == OP_READ_RESET) begin
      cyc_data = DW'(K_ARRAY_MODE);
      is_last  = 1'b1;
    end else if (op == OP_QUERY) begin
      if (s == 0) begin
        cyc_addr = AW'(A_QRY_CMD);
        cyc_data = DW'(K_QUERY);
      end else begin
        is_read  = 1'b1;
        cyc_addr = AW'(A_QRY_DATA) + AW'(s - 1);
        is_last  = (s == 4);
      end
    end else if (s == 0) begin
      cyc_addr = AW'(A_KEY_HI);
      cyc_data = DW'(K_KEY1);
    end else if (s == 1) begin
      cyc_addr = AW'(A_KEY_LO);
      cyc_data = DW'(K_KEY2);
    end else if (op == OP_READ_ID) begin
      if (s == 2) begin
        cyc_addr = AW'(A_KEY_HI);
        cyc_data = DW'(K_IDENT);
      end else begin
        is_read  = 1'b1;
        cyc_addr = (s < 5) ? AW'(s - 3) : AW'(s + 9);
        is_last  = (s == 6);
      end
    end else if (op == OP_PROG) begin
      if (s == 2) begin
        cyc_addr = AW'(A_KEY_HI);
        cyc_data = DW'(K_WORD_PROG);
      end else begin
        cyc_addr = base;
        cyc_data = prog_word;
        is_last  = 1'b1;
      end
    end else if (op == OP_BUF_PROG) begin
      if (s == 2) begin
        cyc_addr = base;
        cyc_data = DW'(K_BUF_LOAD);
      end else if (s == 3) begin
        cyc_addr = base;
        cyc_data = DW'(n - 1);
      end else if (s < 4 + n) begin
        cyc_addr   = base + AW'(s - 4);
        cyc_data   = stream_word;
        takes_word = 1'b1;
      end else begin
        cyc_addr = base + AW'(n - 1);
        cyc_data = DW'(K_BUF_COMMIT);
        is_last  = 1'b1;
      end
    end else if (op == OP_SECT_ERASE || op == OP_CHIP_ERASE) begin
      if (s == 2) begin
        cyc_addr = AW'(A_KEY_HI);
        cyc_data = DW'(K_ERASE_ARM);
      end else if (s == 3) begin
        cyc_addr = AW'(A_KEY_HI);
        cyc_data = DW'(K_KEY1);
      end else if (s == 4) begin
        cyc_addr = AW'(A_KEY_LO);
        cyc_data = DW'(K_KEY2);
      end else begin
        cyc_addr = (op == OP_SECT_ERASE) ? base : AW'(A_KEY_HI);
        cyc_data = (op == OP_SECT_ERASE) ? DW'(K_SECTOR) : DW'(K_WHOLE);
        is_last  = 1'b1;
      end
    end
  end

endmodule

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq import nor_seq_pkg::*; #(
  parameter int AW        = 20,
  parameter int DW        = 16,
  parameter int MAXW      = 16,
  parameter int WR_CYC    = 4,
  parameter bit BYTE_MODE = 1'b0
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       req_start,
  input  logic [2:0]                 req_op,
  input  logic [AW-1:0]              req_addr,
  input  logic [DW-1:0]              req_data,
  input  logic [$clog2(MAXW+1)-1:0]  req_count,
  output logic                       busy,
  output logic                       done,
  output logic                       data_take,
  output logic [DW-1:0]              rd_data,
  output logic                       rd_valid,
  output logic [AW:0]                flash_addr,
  output logic [DW-1:0]              flash_dout,
  output logic                       flash_doe,
  input  logic [DW-1:0]              flash_din,
  output logic                       flash_ce_n,
  output logic                       flash_we_n,
  output logic                       flash_oe_n
);
  localparam int CW  = $clog2(MAXW + 1);
  localparam int SW  = $clog2(MAXW + 6);
  localparam int FAW = AW + 1;

  seq_st_e       st;
  nor_op_e       op_r;
  logic [SW-1:0] step;
  logic [AW-1:0] addr_r;
  logic [DW-1:0] word_r;
  logic [CW-1:0] cnt_r;
  logic          last_r;
  logic          req_ok;
  logic          fin;

  logic          p_rd, p_last, p_take;
  logic [AW-1:0] p_addr;
  logic [DW-1:0] p_data;
  logic [FAW-1:0] bus_addr;

  always_comb begin
    case (nor_op_e'(req_op))
      OP_NONE:     req_ok = 1'b0;
      OP_BUF_PROG: req_ok = (req_count != '0) && (int'(req_count) <= MAXW);
      default:     req_ok = 1'b1;
    endcase
  end

  nor_seq_plan #(.AW(AW), .DW(DW), .MAXW(MAXW), .SW(SW), .CW(CW)) u_plan (
    .op(op_r), .step(step), .base(addr_r), .prog_word(word_r),
    .stream_word(req_data), .count(cnt_r),
    .is_read(p_rd), .cyc_addr(p_addr), .cyc_data(p_data),
    .is_last(p_last), .takes_word(p_take)
  );

  nor_strobe_timer #(.WR_CYC(WR_CYC)) u_timer (
    .clk(clk), .rst(rst), .run(st == ST_STROBE), .fin(fin)
  );

  generate
    if (BYTE_MODE) begin : g_byte_addr
      assign bus_addr = {p_addr, 1'b0};
    end else begin : g_word_addr
      assign bus_addr = {1'b0, p_addr};
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      op_r       <= OP_READ_RESET;
      step       <= '0;
      addr_r     <= '0;
      word_r     <= '0;
      cnt_r      <= '0;
      last_r     <= 1'b0;
      busy       <= 1'b0;
      done       <= 1'b0;
      data_take  <= 1'b0;
      rd_data    <= '0;
      rd_valid   <= 1'b0;
      flash_addr <= '0;
      flash_dout <= '0;
      flash_doe  <= 1'b0;
      flash_ce_n <= 1'b1;
      flash_we_n <= 1'b1;
      flash_oe_n <= 1'b1;
    end else begin
      done      <= 1'b0;
      data_take <= 1'b0;
      rd_valid  <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (req_start && req_ok) begin
            op_r   <= nor_op_e'(req_op);
            addr_r <= req_addr;
            word_r <= req_data;
            cnt_r  <= req_count;
            step   <= '0;
            last_r <= 1'b0;
            busy   <= 1'b1;
            st     <= ST_GAP;
          end
        end
        ST_GAP: begin
          if (last_r) begin
            busy <= 1'b0;
            done <= 1'b1;
            st   <= ST_IDLE;
          end else begin
            flash_addr <= bus_addr;
            flash_dout <= p_data;
            flash_doe  <= !p_rd;
            flash_ce_n <= 1'b0;
            flash_we_n <= p_rd;
            flash_oe_n <= !p_rd;
            data_take  <= p_take;
            last_r     <= p_last;
            st         <= ST_STROBE;
          end
        end
        default: begin
          if (fin) begin
            if (!flash_oe_n) begin
              rd_data  <= flash_din;
              rd_valid <= 1'b1;
            end
            flash_doe  <= 1'b0;
            flash_ce_n <= 1'b1;
            flash_we_n <= 1'b1;
            flash_oe_n <= 1'b1;
            step       <= step + 1'b1;
            st         <= ST_GAP;
          end
        end
      endcase
    end
  end

  // R3: write and output enables are never both active
  p_we_oe_excl_r3: assert property (@(posedge clk) disable iff (rst)
    !(!flash_we_n && !flash_oe_n));

  // R3: any strobe implies chip enable
  p_strobe_in_ce_r3: assert property (@(posedge clk) disable iff (rst)
    (!flash_we_n || !flash_oe_n) |-> !flash_ce_n);

  // R3: data bus driven during writes
  p_write_drives_r3: assert property (@(posedge clk) disable iff (rst)
    !flash_we_n |-> flash_doe);

  // R8: data bus released during reads
  p_read_released_r8: assert property (@(posedge clk) disable iff (rst)
    !flash_oe_n |-> !flash_doe);

  // R2: bus quiet while idle
  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (flash_ce_n && !flash_doe));

  // R2: done marks the fall of busy and lasts one cycle
  p_done_ends_busy_r2: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy)));
  p_done_pulse_r2: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R2: latched operation unaffected by requests during a sequence
  p_op_stable_r2: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(op_r));

  // R8: read data appears only right after an output-enable strobe
  p_rdvalid_after_read_r8: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(!flash_oe_n));

  // R10: a word is taken only by a write cycle
  p_take_on_write_r10: assert property (@(posedge clk) disable iff (rst)
    data_take |-> !flash_we_n);

endmodule

// File: tb/nor_cmd_seq_bench.sv
module nor_cmd_seq_bench;
  localparam int AW   = 16;
  localparam int DW   = 16;
  localparam int MAXW = 16;
  localparam int WR   = 3;
  localparam int CW   = $clog2(MAXW + 1);
  localparam int FAW  = AW + 1;

  localparam logic [2:0] O_RST = 3'd0, O_ID = 3'd1, O_QRY = 3'd2, O_PRG = 3'd3,
                         O_BUF = 3'd4, O_SEC = 3'd5, O_CHP = 3'd6, O_BAD = 3'd7;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic          req_start = 1'b0;
  logic [2:0]    req_op = '0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_data = '0;
  logic [CW-1:0] req_count = '0;

  logic busy, done, take, rd_valid, doe, ce_n, we_n, oe_n;
  logic [DW-1:0] rd_data, dout, din;
  logic [FAW-1:0] faddr;
  logic busy8, done8, take8, rd_valid8, doe8, ce_n8, we_n8, oe_n8;
  logic [DW-1:0] rd_data8, dout8, din8;
  logic [FAW-1:0] faddr8;

  function automatic logic [DW-1:0] fmodel(input logic [AW-1:0] a);
    return a ^ 16'h5A3C;
  endfunction

  function automatic logic [DW-1:0] bword(input int i);
    return 16'hB000 + 16'(i * 273);
  endfunction

  assign din  = fmodel(faddr[AW-1:0]);
  assign din8 = fmodel(faddr8[AW:1]);

  nor_cmd_seq #(.AW(AW), .DW(DW), .MAXW(MAXW), .WR_CYC(WR), .BYTE_MODE(1'b0)) u_nor_cmd_seq (
    .clk(clk), .rst(rst), .req_start(req_start), .req_op(req_op), .req_addr(req_addr),
    .req_data(req_data), .req_count(req_count), .busy(busy), .done(done), .data_take(take),
    .rd_data(rd_data), .rd_valid(rd_valid), .flash_addr(faddr), .flash_dout(dout),
    .flash_doe(doe), .flash_din(din), .flash_ce_n(ce_n), .flash_we_n(we_n), .flash_oe_n(oe_n));

  nor_cmd_seq #(.AW(AW), .DW(DW), .MAXW(MAXW), .WR_CYC(WR), .BYTE_MODE(1'b1)) u_nor_cmd_seq_b8 (
    .clk(clk), .rst(rst), .req_start(req_start), .req_op(req_op), .req_addr(req_addr),
    .req_data(req_data), .req_count(req_count), .busy(busy8), .done(done8), .data_take(take8),
    .rd_data(rd_data8), .rd_valid(rd_valid8), .flash_addr(faddr8), .flash_dout(dout8),
    .flash_doe(doe8), .flash_din(din8), .flash_ce_n(ce_n8), .flash_we_n(we_n8), .flash_oe_n(oe_n8));

  int checks = 0;
  int fails  = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // bus monitor
  logic [FAW-1:0] log_a [32];
  logic [DW-1:0]  log_d [32];
  bit             log_r [32];
  int             log_n = 0;
  logic [DW-1:0]  rdl   [8];
  int             rd_n = 0;
  int             run = 0;
  int             bad_width = 0;
  int             bad_bus = 0;
  int             bad_b8 = 0;

  always @(negedge clk) begin
    if (!rst) begin
      if (!ce_n) begin
        if (run == 0 && log_n < 32) begin
          log_a[log_n] = faddr;
          log_d[log_n] = dout;
          log_r[log_n] = !oe_n;
          log_n++;
        end
        if (!we_n && (!doe || !oe_n)) bad_bus++;
        if (!oe_n && (doe || !we_n)) bad_bus++;
        if (we_n && oe_n) bad_bus++;
        run++;
      end else begin
        if (run != 0 && run != WR) bad_width++;
        run = 0;
        if (doe || !we_n || !oe_n) bad_bus++;
      end
      if (rd_valid && rd_n < 8) begin
        rdl[rd_n] = rd_data;
        rd_n++;
      end
      if (faddr8 != {faddr[AW-1:0], 1'b0} || ce_n8 != ce_n || we_n8 != we_n ||
          oe_n8 != oe_n || doe8 != doe || dout8 != dout || busy8 != busy ||
          done8 != done || take8 != take || rd_valid8 != rd_valid ||
          (rd_valid && rd_data8 != rd_data))
        bad_b8++;
    end
  end

  // expected sequence
  logic [AW-1:0] e_a [32];
  logic [DW-1:0] e_d [32];
  bit            e_r [32];
  int            e_n;

  task automatic push(input bit r, input logic [AW-1:0] a, input logic [DW-1:0] d);
    e_a[e_n] = a;
    e_d[e_n] = d;
    e_r[e_n] = r;
    e_n++;
  endtask

  task automatic do_op(input logic [2:0] op, input logic [AW-1:0] a, input logic [DW-1:0] w,
                       input int n, input bit inject, input string req);
    int busy_cnt, cyc, widx, nrd, bw0, bb0, b80;
    bit fin_seen, seq_ok;
    e_n = 0;
    if (op != O_QRY && op != O_RST) begin
      push(0, 16'h0555, 16'h00AA);
      push(0, 16'h02AA, 16'h0055);
    end
    case (op)
      O_RST: push(0, 16'h0000, 16'h00F0);
      O_ID: begin
        push(0, 16'h0555, 16'h0090);
        push(1, 16'h0000, 0); push(1, 16'h0001, 0);
        push(1, 16'h000E, 0); push(1, 16'h000F, 0);
      end
      O_QRY: begin
        push(0, 16'h0055, 16'h0098);
        for (int k = 0; k < 4; k++) push(1, 16'h0010 + 16'(k), 0);
      end
      O_PRG: begin
        push(0, 16'h0555, 16'h00A0);
        push(0, a, w);
      end
      O_BUF: begin
        push(0, a, 16'h0025);
        push(0, a, 16'(n - 1));
        for (int k = 0; k < n; k++) push(0, a + 16'(k), bword(k));
        push(0, a + 16'(n - 1), 16'h0029);
      end
      default: begin
        push(0, 16'h0555, 16'h0080);
        push(0, 16'h0555, 16'h00AA);
        push(0, 16'h02AA, 16'h0055);
        if (op == O_SEC) push(0, a, 16'h0030);
        else             push(0, 16'h0555, 16'h0010);
      end
    endcase
    nrd = 0;
    for (int k = 0; k < e_n; k++) if (e_r[k]) nrd++;

    log_n = 0; rd_n = 0;
    bw0 = bad_width; bb0 = bad_bus; b80 = bad_b8;
    widx = 0;
    req_op = op; req_addr = a; req_count = CW'(n);
    req_data = (op == O_BUF) ? bword(0) : w;
    req_start = 1'b1;
    @(negedge clk);
    req_start = 1'b0;
    busy_cnt = 0; cyc = 0; fin_seen = 0;
    while (!fin_seen && cyc < 3000) begin
      if (busy) busy_cnt++;
      if (done) begin
        fin_seen = 1;
        check(!busy, "R2", "busy at done", longint'(busy), 0);
      end
      if (take) begin
        widx++;
        req_data = bword(widx);
      end
      if (inject && cyc == 5) begin
        req_start = 1'b1; req_op = O_CHP; req_addr = 16'h1234;
      end
      if (inject && cyc == 6) req_start = 1'b0;
      if (!fin_seen) begin
        @(negedge clk);
        cyc++;
      end
    end
    check(fin_seen, "R2", "done seen", longint'(fin_seen), 1);
    @(negedge clk);
    check(!done, "R2", "done one cycle", longint'(done), 0);
    check(busy_cnt == 1 + e_n * (WR + 1), "R2", "busy length", busy_cnt, 1 + e_n * (WR + 1));

    seq_ok = (log_n == e_n);
    for (int k = 0; k < e_n && k < log_n; k++) begin
      if (log_a[k] != {1'b0, e_a[k]} || log_r[k] != e_r[k] || (!e_r[k] && log_d[k] != e_d[k])) begin
        if (seq_ok)
          $display("FAIL %s cycle %0d actual=%0h/%0h expected=%0h/%0h",
                   req, k, log_a[k], log_d[k], e_a[k], e_d[k]);
        seq_ok = 0;
      end
    end
    if (!seq_ok && log_n != e_n)
      $display("FAIL %s cycle count actual=%0d expected=%0d", req, log_n, e_n);
    checks++;
    if (!seq_ok) fails++;
    if (inject) check(seq_ok, "R2", "start while busy ignored", longint'(seq_ok), 1);

    check(bad_width == bw0, "R3", "strobe width errors", bad_width - bw0, 0);
    check(bad_bus == bb0, "R3", "strobe/data bus errors", bad_bus - bb0, 0);
    check(bad_b8 == b80, "R12", "byte-mode mismatches", bad_b8 - b80, 0);
    if (nrd > 0) begin
      check(rd_n == nrd, req, "read count", rd_n, nrd);
      begin
        int j;
        j = 0;
        for (int k = 0; k < e_n; k++) if (e_r[k]) begin
          if (j < rd_n) check(rdl[j] == fmodel(e_a[k]), req, "read data", rdl[j], fmodel(e_a[k]));
          j++;
        end
      end
    end
    if (op == O_BUF) check(widx == n, "R10", "words taken", widx, n);
  endtask

  task automatic reject(input logic [2:0] op, input int n, input string req);
    bit saw;
    saw = 0;
    log_n = 0;
    req_op = op; req_addr = 16'h0400; req_count = CW'(n); req_data = 16'h1111;
    req_start = 1'b1;
    @(negedge clk);
    req_start = 1'b0;
    for (int k = 0; k < 10; k++) begin
      if (busy || !ce_n) saw = 1;
      @(negedge clk);
    end
    check(!saw, req, "rejected request stays idle", longint'(saw), 0);
    check(log_n == 0, req, "rejected request bus cycles", log_n, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(!busy && !done && !take && !rd_valid && !doe, "R1", "reset flags",
          {busy, done, take, rd_valid, doe}, 0);
    check(ce_n && we_n && oe_n, "R1", "reset strobes", {ce_n, we_n, oe_n}, 3'b111);

    do_op(O_RST, 16'h0000, 16'h0000, 0, 0, "R4");
    do_op(O_PRG, 16'h3C5A, 16'hBEEF, 0, 0, "R5");
    do_op(O_PRG, 16'hFFFF, 16'h0001, 0, 0, "R5");
    do_op(O_SEC, 16'h8000, 16'h0000, 0, 1, "R6");
    do_op(O_CHP, 16'h0000, 16'h0000, 0, 0, "R7");
    do_op(O_ID,  16'h0000, 16'h0000, 0, 0, "R8");
    do_op(O_QRY, 16'h0000, 16'h0000, 0, 0, "R9");
    for (int n = 1; n <= MAXW; n++)
      do_op(O_BUF, 16'h2000 + 16'(n * 64), 16'h0000, n, 0, "R10");
    do_op(O_BUF, 16'hFFFA, 16'h0000, 8, 0, "R10");
    reject(O_BAD, 1, "R2");
    reject(O_BUF, 0, "R11");
    reject(O_BUF, MAXW + 1, "R11");
    do_op(O_PRG, 16'h0042, 16'h5555, 0, 0, "R5");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule